// File: doc/BRIEF.md
# Four-Slot TDM Stream Demultiplexer with Header Alignment

This block sits on the receive side of a time-division link. Four slow serial streams were interleaved bit by bit into one fast stream, one bit per fast clock cycle. The block splits that stream back into four lanes. It runs entirely on the fast clock and produces a one-cycle frame strobe once per slow period, which is every four fast cycles.

The transmitter's slot counter may start in any state, so the receiver cannot assume that the first bit belongs to lane 0. The block therefore searches every incoming bit for a fixed 8-bit alignment word. The two bits after that word give the slot number of the next bit, and the block loads its slot counter from them. From then on, lane k always carries the transmitter's stream k.

A header that appears again later realigns the counter and raises a one-cycle flag. Each lane has its own valid flag, so that lanes not yet filled after an alignment are marked as such. Downstream consumers treat each lane independently. They find their own start-of-transmission patterns and discard any leading zeros.

Top module: `tdm_slot_demux`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, lane data, lane valid flags, frame strobe, lock and realign flags are all 0.
- R2: A header is the alignment word 8'hB5, received most significant bit first, followed by a 2-bit slot number, also MSB first. The lock flag rises on the clock edge that samples the last slot bit, and it stays high until reset.
- R3: Before the first header, lane data and lane valid flags stay 0 and the frame strobe never pulses, whatever bits arrive.
- R4: The first line bit after the header's last slot bit goes to the lane whose index equals the slot number. Each following bit goes to the next lane index, and lane 3 is followed by lane 0.
- R5: At each frame strobe, the valid flag of lane k is 1 exactly when lane k received a bit since the latest of: the lock, the last realignment, or the previous strobe. Lane 3 is therefore always valid at a strobe.
- R6: The frame strobe is high for one cycle, in the cycle after the edge that samples a lane 3 bit. All four lane data bits and valid flags update together at that point and hold their values until the next strobe.
- R7: While locked, every line bit is stored as lane data, including the bits of a later header. A realignment discards a partly filled frame. The exception is a frame whose lane 3 bit is the header's last slot bit: that frame is still presented.
- R8: A header detected while already locked reloads the slot counter and raises the realign flag for exactly one cycle. The header that first brings the block into lock does not raise it.
- R9: The search for the alignment word runs over every received bit, whether or not the block is locked. The window keeps shifting while the slot bits are captured, and a new match is accepted once the slot capture has finished.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast line clock; one line bit per cycle |
| rst_n | input | 1 | Synchronous reset, active low |
| line_i | input | 1 | Multiplexed serial input bit |
| lane_data_o | output | 4 | Recovered bit for each lane; bit k is lane k |
| lane_valid_o | output | 4 | Per-lane valid flag for the presented frame |
| frame_strobe_o | output | 1 | One-cycle pulse when a new frame is presented |
| locked_o | output | 1 | High once the first header has been received |
| realign_o | output | 1 | One-cycle pulse when a later header reloads the slot counter |

## Verification
The case that needs the most care is a realignment that lands on the same edge as the completion of a frame. The header's last slot bit is then still stored as lane 3 data and the frame is presented, while the counter and the fill mask take their reload values. The bench provokes this by varying the amount of padding data placed before each new header, so that the old slot phase at the reload edge alternates between 1 and 3. Every cycle, it judges the strobe, all lane bits and all valid flags against a bit-level model of the requirements.

// File: rtl/tdm_pkg.sv
// Shared types for the TDM demultiplexer.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package tdm_pkg;
    // Header search state: hunting for the alignment word, or capturing slot bits.
    typedef enum logic {
        HDR_HUNT = 1'b0,
        HDR_SLOT = 1'b1
    } hdr_state_e;
endpackage

// File: rtl/tdm_hdr_detect.sv
// Header detector: shifts every line bit into a window and compares it with
// the alignment word. After a match it captures SLOT_W slot bits, MSB first.
// hit_o is combinational and high in the cycle whose line bit is the last
// slot bit; slot_o is valid in that cycle.
// Assumes: SYNC_W >= 2 and SLOT_W >= 1.
module tdm_hdr_detect
    import tdm_pkg::*;
#(
    parameter int          SYNC_W    = 8,
    parameter logic [SYNC_W-1:0] SYNC_WORD = 8'hB5,
    parameter int          SLOT_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_i,
    output logic              hit_o,
    output logic [SLOT_W-1:0] slot_o
);
    localparam int CNT_W = (SLOT_W > 1) ? $clog2(SLOT_W) : 1;

    hdr_state_e         state_q;
    logic [SYNC_W-1:0]  win_q;
    logic [SYNC_W-1:0]  win_nxt;
    logic [SLOT_W-1:0]  acc_q;
    logic [CNT_W-1:0]   bcnt_q;
    logic               last_bit;

    // Next window content and the slot value formed with the current bit.
    always_comb begin
        win_nxt  = {win_q[SYNC_W-2:0], line_i};
        slot_o   = SLOT_W'({acc_q, line_i});
        last_bit = (bcnt_q == CNT_W'(SLOT_W - 1));
        hit_o    = (state_q == HDR_SLOT) && last_bit;
    end

    // Window shift and hunt/capture sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= HDR_HUNT;
            win_q   <= '0;
            acc_q   <= '0;
            bcnt_q  <= '0;
        end else begin
            win_q <= win_nxt;
            if (state_q == HDR_HUNT) begin
                if (win_nxt == SYNC_WORD) begin
                    state_q <= HDR_SLOT;
                    acc_q   <= '0;
                    bcnt_q  <= '0;
                end
            end else begin
                acc_q  <= slot_o;
                bcnt_q <= bcnt_q + CNT_W'(1);
                if (last_bit) begin
                    state_q <= HDR_HUNT;
                end
            end
        end
    end

    AST_HIT_AFTER_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == HDR_SLOT && bcnt_q == '0) |-> $past(win_nxt == SYNC_WORD)); // R9
    AST_HIT_LEAVES_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |=> (state_q == HDR_HUNT)); // R9
endmodule

// File: rtl/tdm_slot_ctrl.sv
// Slot controller: holds the lock flag and the current slot number.
// A header load sets the slot to the header value; otherwise, while locked,
// the slot advances by one per cycle and wraps after the last lane.
// Assumes: load_i is a single-cycle pulse from the header detector.
module tdm_slot_ctrl #(
    parameter int NUM_LANES = 4,
    parameter int SLOT_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [SLOT_W-1:0] load_slot_i,
    output logic              locked_o,
    output logic [SLOT_W-1:0] slot_o,
    output logic              realign_o
);
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(NUM_LANES - 1);

    // Lock, slot counter and realign pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked_o  <= 1'b0;
            slot_o    <= '0;
            realign_o <= 1'b0;
        end else begin
            realign_o <= load_i && locked_o;
            if (load_i) begin
                locked_o <= 1'b1;
                slot_o   <= load_slot_i;
            end else if (locked_o) begin
                slot_o <= (slot_o == LAST) ? '0 : slot_o + SLOT_W'(1);
            end
        end
    end

    AST_LOAD_TAKES_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (locked_o && slot_o == $past(load_slot_i))); // R2
    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        locked_o |=> locked_o); // R2
    AST_REALIGN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        realign_o |=> !realign_o); // R8
endmodule

// File: rtl/tdm_lane_collect.sv
// Lane collector: while locked, stores each line bit into the lane selected
// by the slot number and tracks which lanes were filled. When the last lane
// is written, it presents all lanes and their fill mask and pulses the strobe.
// A load clears the fill mask; the write on that same edge still uses the
// old slot number.
// Assumes: slot_i and locked_i come from the slot controller.
module tdm_lane_collect #(
    parameter int NUM_LANES = 4,
    parameter int SLOT_W    = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 line_i,
    input  logic                 locked_i,
    input  logic                 load_i,
    input  logic [SLOT_W-1:0]    slot_i,
    output logic [NUM_LANES-1:0] data_o,
    output logic [NUM_LANES-1:0] valid_o,
    output logic                 strobe_o
);
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(NUM_LANES - 1);

    logic [NUM_LANES-1:0] buf_q, buf_nxt;
    logic [NUM_LANES-1:0] fill_q, fill_nxt;

    // Buffer and fill mask as they would be with the current bit written.
    always_comb begin
        buf_nxt          = buf_q;
        buf_nxt[slot_i]  = line_i;
        fill_nxt         = fill_q;
        fill_nxt[slot_i] = 1'b1;
    end

    // Lane storage, frame presentation and fill tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q    <= '0;
            fill_q   <= '0;
            data_o   <= '0;
            valid_o  <= '0;
            strobe_o <= 1'b0;
        end else begin
            strobe_o <= 1'b0;
            if (locked_i) begin
                buf_q <= buf_nxt;
                if (slot_i == LAST) begin
                    data_o   <= buf_nxt;
                    valid_o  <= fill_nxt;
                    strobe_o <= 1'b1;
                    fill_q   <= '0;
                end else begin
                    fill_q <= fill_nxt;
                end
            end
            if (load_i) begin
                fill_q <= '0;
            end
        end
    end

    AST_LAST_LANE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |-> valid_o[NUM_LANES-1]); // R5
    AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_o |-> ($stable(valid_o) && $stable(data_o))); // R6
    AST_STROBE_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |-> $past(locked_i)); // R3
endmodule

// File: rtl/tdm_slot_demux.sv
// Top level: header detector, slot controller and lane collector on the fast
// clock. Splits one serial stream into NUM_LANES lanes, aligned by an in-band
// header that carries the slot number of the next bit.
// Assumes: NUM_LANES is a power of two and the line bit is already
// synchronous to clk.
module tdm_slot_demux #(
    parameter int                NUM_LANES = 4,
    parameter int                SYNC_W    = 8,
    parameter logic [SYNC_W-1:0] SYNC_WORD = 8'hB5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 line_i,
    output logic [NUM_LANES-1:0] lane_data_o,
    output logic [NUM_LANES-1:0] lane_valid_o,
    output logic                 frame_strobe_o,
    output logic                 locked_o,
    output logic                 realign_o
);
    localparam int SLOT_W = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1;

    logic              hdr_hit;
    logic [SLOT_W-1:0] hdr_slot;
    logic [SLOT_W-1:0] cur_slot;

    tdm_hdr_detect #(
        .SYNC_W   (SYNC_W),
        .SYNC_WORD(SYNC_WORD),
        .SLOT_W   (SLOT_W)
    ) u_hdr (
        .clk   (clk),
        .rst_n (rst_n),
        .line_i(line_i),
        .hit_o (hdr_hit),
        .slot_o(hdr_slot)
    );

    tdm_slot_ctrl #(
        .NUM_LANES(NUM_LANES),
        .SLOT_W   (SLOT_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (hdr_hit),
        .load_slot_i(hdr_slot),
        .locked_o   (locked_o),
        .slot_o     (cur_slot),
        .realign_o  (realign_o)
    );

    tdm_lane_collect #(
        .NUM_LANES(NUM_LANES),
        .SLOT_W   (SLOT_W)
    ) u_coll (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_i  (line_i),
        .locked_i(locked_o),
        .load_i  (hdr_hit),
        .slot_i  (cur_slot),
        .data_o  (lane_data_o),
        .valid_o (lane_valid_o),
        .strobe_o(frame_strobe_o)
    );

    AST_QUIET_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !locked_o |-> (lane_valid_o == '0 && lane_data_o == '0 && !frame_strobe_o)); // R3
    AST_REALIGN_WHEN_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        realign_o |-> (locked_o && $past(locked_o))); // R8
endmodule

// File: tb/tdm_slot_demux_test.sv
// Bench: sweeps all four header slot numbers, with padding chosen so that
// reloads fall on different slot phases, including a lane 3 edge. Every
// cycle it compares all outputs with a bit-level model of the requirements.
module tdm_slot_demux_test;
    localparam int         N    = 4;
    localparam logic [7:0] SYNC = 8'hB5;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         line_i = 1'b0;
    logic [N-1:0] lane_data_o, lane_valid_o;
    logic         frame_strobe_o, locked_o, realign_o;

    int  vectors = 0;
    int  fails   = 0;
    bit  done    = 1'b0;

    // Model state.
    logic [7:0]   m_win = '0;
    bit           m_cap = 1'b0;
    int           m_k = 0;
    int           m_acc = 0;
    bit           m_locked = 1'b0;
    int           m_cnt = 0;
    logic [N-1:0] m_buf = '0, m_mask = '0, m_data = '0, m_valid = '0;
    bit           m_strobe = 1'b0, m_realign = 1'b0;
    int           lane_seq [N];

    always #10 clk = ~clk;

    tdm_slot_demux uut (
        .clk(clk), .rst_n(rst_n), .line_i(line_i),
        .lane_data_o(lane_data_o), .lane_valid_o(lane_valid_o),
        .frame_strobe_o(frame_strobe_o), .locked_o(locked_o),
        .realign_o(realign_o)
    );

    task automatic cmp(input string req, input string what,
                       input logic [N-1:0] act, input logic [N-1:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    // Compare every output with the model; the tag follows the requirement.
    task automatic check_all(input bit in_reset);
        string rq_lock;
        rq_lock = in_reset ? "R1" : "R2";
        cmp(in_reset ? "R1" : "R4", "lane_data", lane_data_o, m_data);
        cmp(in_reset ? "R1" : "R5", "lane_valid", lane_valid_o, m_valid);
        cmp(in_reset ? "R1" : "R6", "strobe", {3'b0, frame_strobe_o}, {3'b0, m_strobe});
        cmp(rq_lock, "locked", {3'b0, locked_o}, {3'b0, m_locked});
        cmp(in_reset ? "R1" : "R8", "realign", {3'b0, realign_o}, {3'b0, m_realign});
        if (!m_locked) cmp("R3", "quiet_before_lock", lane_valid_o | lane_data_o, '0);
    endtask

    // Model of one line bit (R2, R4..R9).
    task automatic model_step(input logic b);
        bit hit;
        int hslot;
        hit = 1'b0;
        hslot = 0;
        m_win = {m_win[6:0], b};
        if (!m_cap) begin
            if (m_win == SYNC) begin
                m_cap = 1'b1;
                m_k = 0;
                m_acc = 0;
            end
        end else begin
            m_acc = (m_acc * 2) + int'(b);
            m_k++;
            if (m_k == 2) begin
                hit = 1'b1;
                hslot = m_acc;
                m_cap = 1'b0;
            end
        end
        m_strobe = 1'b0;
        if (m_locked) begin
            m_buf[m_cnt]  = b;
            m_mask[m_cnt] = 1'b1;
            if (m_cnt == N - 1) begin
                m_data   = m_buf;
                m_valid  = m_mask;
                m_strobe = 1'b1;
                m_mask   = '0;
            end
            m_cnt = (m_cnt + 1) % N;
        end
        m_realign = hit && m_locked;
        if (hit) begin
            m_locked = 1'b1;
            m_cnt = hslot;
            m_mask = '0;
        end
    endtask

    task automatic push(input logic b);
        @(negedge clk);
        check_all(1'b0);
        line_i = b;
        model_step(b);
    endtask

    task automatic send_header(input int slot);
        for (int i = 7; i >= 0; i--) push(SYNC[i]);
        push(logic'((slot >> 1) & 1));
        push(logic'(slot & 1));
    endtask

    // Lane bit for lane k, element n: a distinct pattern per lane (R4).
    function automatic logic lane_bit(input int k, input int n);
        return logic'(((n * 7 + k * 5 + (n >> 2)) >> 1) & 1);
    endfunction

    // Data bits laid out as the transmitter would, starting at slot s.
    task automatic send_data(input int s, input int nbits);
        for (int i = 0; i < nbits; i++) begin
            int k;
            k = (s + i) % N;
            push(lane_bit(k, lane_seq[k]));
            lane_seq[k]++;
        end
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < N; k++) lane_seq[k] = 0;
        // R1: reset state, sampled during reset and right after release.
        repeat (3) @(negedge clk);
        check_all(1'b1);
        rst_n = 1'b1;
        @(negedge clk);
        check_all(1'b1);
        // R3: bits before any header leave the lanes quiet.
        for (int i = 0; i < 14; i++) push(logic'(i & 1));
        for (int i = 0; i < 6; i++) push(1'b1);
        // R2, R4, R5, R7, R8, R9: each slot start, then padding that moves
        // the phase of the next reload (reload on lane 3 for odd s).
        for (int s = 0; s < N; s++) begin
            send_header(s);
            send_data(s, 24);
            send_data(s, s);
        end
        // Back-to-back headers: realign with no data between them (R8).
        send_header(3);
        send_header(1);
        send_data(1, 12);
        for (int i = 0; i < 4; i++) push(1'b0);
        @(negedge clk);
        check_all(1'b0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule